// File: doc/BRIEF.md
# Robbed-Bit Signaling Transmit Inserter

This block sits in the transmit path of a T1 framer. It takes a stream of channel bytes, each tagged with a channel index and a frame index, and overwrites the least significant bit of the bytes that carry signaling. The values come from twelve host-writable 8-bit registers. Together these hold up to four signaling bits (A, B, C, D) for each of the 24 channels.

The host does not feed the line directly. Whenever the first byte of a multiframe arrives, all twelve registers are copied in one step into an outgoing store, and only that store feeds the inserter. The host can therefore rewrite its registers at any time without disturbing the multiframe in flight. A one-cycle interrupt pulse marks each multiframe start so the host knows when to write the next set.

A mode input selects the superframe (two signaling bits, 12-frame multiframe) or the extended superframe (four signaling bits, 24-frame multiframe). A global enable turns insertion off entirely. The output is the modified byte stream, delayed by exactly one clock.

Top module: `rbs_tx_inserter`

## Requirements
- R1: After reset, out_valid and mf_irq are 0, and every host register and store bit is 0. Signaling frames that arrive before any write therefore get LSB 0.
- R2: When wr_en is 1, wr_addr values 0..11 write wr_data into host register wr_addr. Register r holds signaling letter r/3 (0=A, 1=B, 2=C, 3=D) for channels 8*(r%3) .. 8*(r%3)+7, and bit b is channel 8*(r%3)+b (channels are numbered 0..23). Writes with wr_addr 12..15 are ignored.
- R3: A strobe with in_chan=0 and in_frame=0 is a multiframe boundary. At the clock edge that accepts it, all twelve registers are copied into the store at once. A write in that same cycle does not reach the store until the next boundary.
- R4: Register writes between boundaries do not change the bits inserted in the current multiframe.
- R5: mf_irq is 1 for exactly the cycle in which the output byte of a boundary strobe appears, and 0 otherwise.
- R6: With mode_esf=0, frame indices 5 and 11 (0-based) carry A and B. Every other frame index, including 12..23, passes through unchanged.
- R7: With mode_esf=1, frame indices 5, 11, 17 and 23 carry A, B, C and D. All other frames pass through unchanged.
- R8: On an inserted byte, bit 0 is replaced by the store bit and bits 7..1 are unchanged.
- R9: While ins_enable is 0 at the input strobe, that byte passes through unchanged.
- R10: out_valid equals in_valid delayed by one cycle. When out_valid is 0, out_byte holds its last value.
- R11: Bytes with in_chan 24..31 are never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register index |
| wr_data | input | 8 | Host register write data |
| ins_enable | input | 1 | Global signaling insertion enable |
| mode_esf | input | 1 | 1 = extended superframe, 0 = superframe |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input channel byte |
| in_chan | input | 5 | Channel index of the input byte |
| in_frame | input | 5 | Frame index within the multiframe (0-based) |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Output channel byte |
| mf_irq | output | 1 | Multiframe-start pulse |

## Verification
Whole multiframes are streamed in both modes with bytes whose LSB is 1 and, separately, with bytes whose upper bits vary. This separates a stuck or zero insertion from a missing or misplaced one, and shows whether the upper bits are touched. Register writes are placed between boundaries, mid-multiframe, on the boundary cycle itself, and at the unused addresses, to show that the two-level latching works and that bad addresses are dropped. Further runs use the insertion enable turned off, channel indices out of range, superframe mode fed with frame indices above 11, and strobes with idle gaps. Each of these must leave the bytes untouched while the other cases must modify them.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  // A frame (1-based count f1) carries signaling when f1 is a multiple of
  // the period and the letter index it selects is within the active count.
  function automatic logic is_slot(input int f1, input int period, input int nsig);
    return (f1 % period == 0) && (f1 / period >= 1) && (f1 / period <= nsig);
  endfunction

  // Flat store position for signaling letter sig of channel ch.
  function automatic int flat_pos(input int sig, input int ch, input int nch);
    return sig * nch + ch;
  endfunction
endpackage

// File: rtl/rbs_host_regs.sv
module rbs_host_regs #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 12,
  parameter int ADDR_W   = 4,
  localparam int FLAT_W  = REG_W * NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [FLAT_W-1:0] regs_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_flat[r*REG_W +: REG_W] <= '0;
      else if (wr_en && (int'(wr_addr) == r))
        regs_flat[r*REG_W +: REG_W] <= wr_data;
    end
  end
endmodule

// File: rtl/rbs_sig_store.sv
module rbs_sig_store #(
  parameter int FLAT_W = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLAT_W-1:0] d_flat,
  output logic [FLAT_W-1:0] q_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_flat <= '0;
    else if (load) q_flat <= d_flat;
  end
endmodule

// File: rtl/rbs_slot_decode.sv
module rbs_slot_decode #(
  parameter int NUM_CH     = 24,
  parameter int NUM_SIG    = 4,
  parameter int NUM_SIG_SF = 2,
  parameter int SIG_PERIOD = 6,
  parameter int CH_W       = 5,
  parameter int FR_W       = 5,
  parameter int POS_W      = 7
) (
  input  logic [CH_W-1:0]  chan,
  input  logic [FR_W-1:0]  frame,
  input  logic             esf,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  int f1;
  int nsig;
  int sig;
  always_comb begin
    f1   = int'(frame) + 1;
    nsig = esf ? NUM_SIG : NUM_SIG_SF;
    sig  = (f1 / SIG_PERIOD) - 1;
    hit  = (int'(chan) < NUM_CH) && rbs_pkg::is_slot(f1, SIG_PERIOD, nsig);
    pos  = hit ? POS_W'(rbs_pkg::flat_pos(sig, int'(chan), NUM_CH)) : '0;
  end
endmodule

// File: rtl/rbs_tx_inserter.sv
module rbs_tx_inserter #(
  parameter int GROUP_W    = 8,
  parameter int NUM_GROUPS = 3,
  parameter int NUM_SIG    = 4,
  parameter int NUM_SIG_SF = 2,
  parameter int SIG_PERIOD = 6,
  parameter int BYTE_W     = 8,
  localparam int NUM_CH    = GROUP_W * NUM_GROUPS,
  localparam int NUM_REGS  = NUM_SIG * NUM_GROUPS,
  localparam int FLAT_W    = GROUP_W * NUM_REGS,
  localparam int ADDR_W    = $clog2(NUM_REGS),
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int FR_W      = $clog2(NUM_SIG * SIG_PERIOD),
  localparam int POS_W     = $clog2(FLAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GROUP_W-1:0] wr_data,
  input  logic              ins_enable,
  input  logic              mode_esf,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [FR_W-1:0]   in_frame,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              mf_irq
);
  // Named internal events, observed by the bound checker.
  logic              boundary;
  logic              slot_hit;
  logic [POS_W-1:0]  slot_pos;
  logic [FLAT_W-1:0] regs_flat;
  logic [FLAT_W-1:0] store_flat;
  logic              do_insert;
  logic [BYTE_W-1:0] next_byte;

  assign boundary = in_valid && (in_chan == '0) && (in_frame == '0);

  rbs_host_regs #(.REG_W(GROUP_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  rbs_sig_store #(.FLAT_W(FLAT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(boundary),
    .d_flat(regs_flat), .q_flat(store_flat)
  );

  rbs_slot_decode #(
    .NUM_CH(NUM_CH), .NUM_SIG(NUM_SIG), .NUM_SIG_SF(NUM_SIG_SF),
    .SIG_PERIOD(SIG_PERIOD), .CH_W(CH_W), .FR_W(FR_W), .POS_W(POS_W)
  ) u_dec (
    .chan(in_chan), .frame(in_frame), .esf(mode_esf),
    .hit(slot_hit), .pos(slot_pos)
  );

  assign do_insert = in_valid && ins_enable && slot_hit;
  assign next_byte = do_insert ? {in_byte[BYTE_W-1:1], store_flat[slot_pos]} : in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      mf_irq    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      mf_irq    <= boundary;
      if (in_valid) out_byte <= next_byte;
    end
  end
endmodule

// File: rtl/rbs_tx_inserter_chk.sv
module rbs_tx_inserter_chk #(
  parameter int FLAT_W = 96,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_byte,
  input logic              ins_enable,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              mf_irq,
  input logic              boundary,
  input logic              slot_hit,
  input logic [FLAT_W-1:0] regs_flat,
  input logic [FLAT_W-1:0] store_flat
);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_upper_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_byte[BYTE_W-1:1] == $past(in_byte[BYTE_W-1:1]));
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ins_enable) |=> out_byte == $past(in_byte));
  // R6 and R7: bytes outside signaling slots are never modified.
  assert_nonslot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !slot_hit) |=> out_byte == $past(in_byte));
  assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> mf_irq);
  assert_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !mf_irq);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> store_flat == $past(regs_flat));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(store_flat));
endmodule

bind rbs_tx_inserter rbs_tx_inserter_chk #(.FLAT_W(FLAT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .ins_enable(ins_enable), .out_valid(out_valid), .out_byte(out_byte),
  .mf_irq(mf_irq), .boundary(boundary), .slot_hit(slot_hit),
  .regs_flat(regs_flat), .store_flat(store_flat)
);

// File: tb/rbs_tx_inserter_tb.sv
module rbs_tx_inserter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ins_enable = 1'b0;
  logic       mode_esf = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [4:0] in_chan = '0;
  logic [4:0] in_frame = '0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       mf_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Behavioural reference: host copy, latched copy, expected outputs.
  logic [7:0] m_regs  [12];
  logic [7:0] m_store [12];
  logic       e_valid = 1'b0;
  logic [7:0] e_byte = '0;
  logic       e_irq = 1'b0;

  always #2 clk = ~clk;

  rbs_tx_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ins_enable(ins_enable), .mode_esf(mode_esf), .in_valid(in_valid),
    .in_byte(in_byte), .in_chan(in_chan), .in_frame(in_frame),
    .out_valid(out_valid), .out_byte(out_byte), .mf_irq(mf_irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // Model step at a clock edge, from the inputs currently driven.
  task automatic model_edge();
    int f1, ch, fr, sig, nsig;
    logic hit;
    ch = int'(in_chan);
    fr = int'(in_frame);
    f1 = fr + 1;
    nsig = mode_esf ? 4 : 2;
    hit = in_valid && ins_enable && ch < 24 && (f1 % 6 == 0) && (f1 / 6 <= nsig);
    e_valid = in_valid;
    e_irq = in_valid && ch == 0 && fr == 0;
    if (in_valid) begin
      e_byte = in_byte;
      if (hit) begin
        sig = f1 / 6 - 1;
        e_byte[0] = m_store[sig * 3 + ch / 8][ch % 8];
      end
    end
    if (e_irq)
      for (int i = 0; i < 12; i++) m_store[i] = m_regs[i];
    if (wr_en && int'(wr_addr) < 12) m_regs[int'(wr_addr)] = wr_data;
  endtask

  // Drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input logic v, input logic [7:0] b, input int ch, input int fr,
                      input logic we, input int wa, input logic [7:0] wd);
    in_valid = v; in_byte = b; in_chan = 5'(ch); in_frame = 5'(fr);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("out_valid", {7'd0, out_valid}, {7'd0, e_valid});
    check("out_byte", out_byte, e_byte);
    check("mf_irq", {7'd0, mf_irq}, {7'd0, e_irq});
  endtask

  task automatic host_write(input int wa, input logic [7:0] wd);
    step(1'b0, 8'h00, 0, 0, 1'b1, wa, wd);
  endtask

  // One multiframe; optional mid-multiframe write at frame 8, channel 3.
  task automatic run_mf(input int nframes, input int seed, input logic force_ones,
                        input logic mid_we, input int mid_a, input logic [7:0] mid_d);
    for (int fr = 0; fr < nframes; fr++)
      for (int ch = 0; ch < 24; ch++) begin
        logic [7:0] b;
        logic w;
        b = force_ones ? 8'hFF : 8'((fr * 29 + ch * 7 + seed) ^ (seed >> 3));
        w = mid_we && fr == 8 && ch == 3;
        step(1'b1, b, ch, fr, w, mid_a, mid_d);
      end
  endtask

  initial begin
    for (int i = 0; i < 12; i++) begin m_regs[i] = '0; m_store[i] = '0; end
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("out_valid reset", {7'd0, out_valid}, 8'd0);
    check("mf_irq reset", {7'd0, mf_irq}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ins_enable = 1'b1; mode_esf = 1'b1;
    cur_req = "R1 zero store";
    run_mf(24, 0, 1'b1, 1'b0, 0, 8'h00);

    cur_req = "R2 writes";
    for (int i = 0; i < 12; i++) host_write(i, 8'((i * 53 + 17) ^ 8'hA5));
    for (int i = 12; i < 16; i++) host_write(i, 8'hFF);
    cur_req = "R3 R7 esf load";
    run_mf(24, 1, 1'b1, 1'b0, 0, 8'h00);
    cur_req = "R7 R8 esf data";
    run_mf(24, 77, 1'b0, 1'b0, 0, 8'h00);

    cur_req = "R4 mid write";
    run_mf(24, 5, 1'b1, 1'b1, 10, 8'h3C);
    run_mf(24, 9, 1'b1, 1'b1, 2, 8'hC3);
    cur_req = "R4 next mf";
    run_mf(24, 11, 1'b1, 1'b0, 0, 8'h00);

    cur_req = "R6 sf mode";
    mode_esf = 1'b0;
    run_mf(12, 3, 1'b1, 1'b0, 0, 8'h00);
    run_mf(12, 41, 1'b0, 1'b0, 0, 8'h00);
    cur_req = "R6 sf high frames";
    for (int ch = 0; ch < 24; ch++) begin
      step(1'b1, 8'hFE, ch, 17, 1'b0, 0, 8'h00);
      step(1'b1, 8'hFE, ch, 23, 1'b0, 0, 8'h00);
    end

    cur_req = "R9 disabled";
    mode_esf = 1'b1; ins_enable = 1'b0;
    run_mf(24, 13, 1'b1, 1'b0, 0, 8'h00);
    ins_enable = 1'b1;

    cur_req = "R11 channel range";
    for (int ch = 24; ch < 32; ch++) begin
      step(1'b1, 8'hFF, ch, 5, 1'b0, 0, 8'h00);
      step(1'b1, 8'hFE, ch, 23, 1'b0, 0, 8'h00);
    end

    cur_req = "R3 write on boundary";
    for (int i = 0; i < 12; i++) host_write(i, 8'h00);
    step(1'b1, 8'h11, 0, 0, 1'b1, 0, 8'hFF);
    for (int ch = 0; ch < 8; ch++) step(1'b1, 8'hFF, ch, 5, 1'b0, 0, 8'h00);
    cur_req = "R3 write lands next mf";
    run_mf(24, 2, 1'b1, 1'b0, 0, 8'h00);

    cur_req = "R10 R5 gaps";
    for (int fr = 0; fr < 24; fr++)
      for (int ch = 0; ch < 24; ch++) begin
        step(1'b1, 8'(ch * 3 + fr), ch, fr, 1'b0, 0, 8'h00);
        if ((ch + fr) % 3 == 0) step(1'b0, 8'h5A, ch, 0, 1'b0, 0, 8'h00);
        if (ch == 1) step(1'b0, 8'h00, 0, 0, 1'b0, 0, 8'h00);
      end
    step(1'b0, 8'h00, 0, 0, 1'b0, 0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule